// File: doc/BRIEF.md
# FIFO Threshold Service Request Generator

This block sits between a host that moves data by register access or DMA and a byte-serial bus engine. It holds one byte FIFO per direction. The host writes bytes to be sent into the transmit FIFO and reads received bytes out of the receive FIFO. The serial engine pops transmit bytes and pushes receive bytes one at a time. For each direction the block tells the host when to act. In interrupt mode this is a level request. In DMA mode it is a request that covers a fixed burst of bytes.

Each direction has its own host-side threshold field, stored as the byte count minus one. The serial side always works one byte at a time. A drain mode services the bytes left over when a transfer length is not a multiple of the threshold. A slave-transmit mode asks for data only when the remote master wants a byte that is not there. A per-direction clear acts as a software reset of that FIFO and of its DMA request state machine.

Top module: `xfer_fifo_req`

## Requirements
- R1: While reset is held, both levels read 0. Both DMA requests, both sticky flags and `core_tx_avail` read 0, and `core_rx_space` reads 1.
- R2: A threshold field value F selects a threshold of F+1 bytes. In interrupt mode (`dma_mode`=0), `tx_irq` is high while the transmit FIFO has at least the threshold in free entries. `rx_irq` is high while the receive FIFO holds at least the threshold in bytes. Both are combinational on the current levels.
- R3: The serial side acts as threshold 1. `core_tx_avail` is high exactly when the transmit FIFO is not empty, and `core_rx_space` is high exactly when the receive FIFO is not full. Bytes leave each FIFO in the order they entered. `core_tx_data` and `host_rd_data` show the oldest byte.
- R4: In DMA mode (`dma_mode`=1) both interrupt outputs stay low. A DMA request rises one cycle after its condition holds in the idle state. It stays high until a burst of accepted host transfers completes, then falls in the cycle after the last transfer and stays low for at least two cycles.
- R5: With `drain_en`=1, the receive condition becomes "level not 0" and the transmit condition becomes "free entries not 0". The DMA burst then equals the smaller of the available count and the threshold.
- R6: `rx_drain_cnt` equals the receive level while `drain_en` is 1 and reads 0 otherwise.
- R7: With `slave_tx`=1, the transmit request depends on neither level nor threshold. It is raised after `core_tx_byte_req` is seen while the transmit FIFO is empty. It is withdrawn when the host writes a byte, and the DMA burst is 1 byte.
- R8: A host write to a full transmit FIFO is dropped and sets the sticky `tx_ovf`. A host read of an empty receive FIFO is dropped and sets the sticky `rx_unf`. Each flag is cleared only by reset or by its own clear.
- R9: A clear pulse empties its FIFO, so the level reads 0 in the next cycle. A write or push in the same cycle is lost. The clear returns that direction's DMA state machine to idle and forces that direction's interrupt and DMA outputs low in the same cycle.
- R10: A host write and a serial pop on the transmit FIFO in the same cycle, with the FIFO neither empty nor full, leave the level unchanged and keep byte order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_mode | input | 1 | 1 selects DMA requests, 0 selects interrupt requests |
| drain_en | input | 1 | Service remainder bytes below the threshold |
| slave_tx | input | 1 | Transmit requests follow remote byte requests on an empty FIFO |
| tx_thr_m1 | input | TW (5) | Transmit threshold minus one |
| rx_thr_m1 | input | TW (5) | Receive threshold minus one |
| tx_clr | input | 1 | Software clear of the transmit FIFO and its DMA state |
| rx_clr | input | 1 | Software clear of the receive FIFO and its DMA state |
| host_wr_en | input | 1 | Host writes one byte to the transmit FIFO |
| host_wr_data | input | 8 | Byte written by the host |
| host_rd_en | input | 1 | Host reads one byte from the receive FIFO |
| host_rd_data | output | 8 | Oldest byte in the receive FIFO |
| core_tx_pop | input | 1 | Serial engine takes one transmit byte |
| core_tx_data | output | 8 | Oldest byte in the transmit FIFO |
| core_tx_avail | output | 1 | Transmit FIFO not empty |
| core_tx_byte_req | input | 1 | Remote master asks for a byte |
| core_rx_push | input | 1 | Serial engine delivers one received byte |
| core_rx_data | input | 8 | Received byte |
| core_rx_space | output | 1 | Receive FIFO not full |
| tx_irq | output | 1 | Transmit interrupt request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_irq | output | 1 | Receive interrupt request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_level | output | LW (6) | Bytes held in the transmit FIFO |
| rx_level | output | LW (6) | Bytes held in the receive FIFO |
| rx_drain_cnt | output | LW (6) | Remaining receive bytes while draining |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_unf | output | 1 | Sticky receive underflow |

## Verification
Two events can fall in the same cycle and are provoked on purpose. The first is a software clear together with a host write while a DMA burst is active. The bench expects the request to drop in that same cycle, sampled just after the clear is driven. It then expects the level to read 0 on the next cycle, so the write is lost. The second is a host write together with a serial pop on a partly filled transmit FIFO, judged by an unchanged level and by the next byte at the head.

// File: rtl/xfer_fifo_pkg.sv
package xfer_fifo_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SVC_IDLE   = 2'd0,
    SVC_ACTIVE = 2'd1,
    SVC_GAP    = 2'd2
  } svc_state_e;
endpackage

// File: rtl/xfer_byte_fifo.sv
module xfer_byte_fifo
  import xfer_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [BYTE_W-1:0] push_data,
  input  logic              pop,
  output logic [BYTE_W-1:0] pop_data,
  output logic [LW-1:0]     level,
  output logic              full,
  output logic              empty,
  output logic              push_drop,
  output logic              pop_drop
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [LW-1:0]     count;
  logic              push_ok, pop_ok;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    if (p == PW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign full      = (count == LW'(DEPTH));
  assign empty     = (count == '0);
  assign push_ok   = push & ~full & ~clr;
  assign pop_ok    = pop & ~empty & ~clr;
  assign push_drop = push & full & ~clr;
  assign pop_drop  = pop & empty & ~clr;
  assign pop_data  = mem[rd_ptr];
  assign level     = count;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/xfer_svc_req.sv
module xfer_svc_req
  import xfer_fifo_pkg::*;
#(
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          dma_mode,
  input  logic          cond,
  input  logic [LW-1:0] burst,
  input  logic          xfer,
  output logic          irq,
  output logic          dma_req,
  output logic          arm_evt,
  output logic          done_evt
);
  svc_state_e    state;
  logic [LW-1:0] remain;

  assign arm_evt  = (state == SVC_IDLE) & dma_mode & cond & ~clr;
  assign done_evt = (state == SVC_ACTIVE) & xfer & (remain <= LW'(1)) & ~clr;
  assign irq      = cond & ~dma_mode & ~clr;
  assign dma_req  = (state == SVC_ACTIVE) & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SVC_IDLE;
      remain <= '0;
    end else if (clr) begin
      state  <= SVC_IDLE;
      remain <= '0;
    end else begin
      case (state)
        SVC_IDLE: begin
          if (arm_evt) begin
            state  <= SVC_ACTIVE;
            remain <= burst;
          end
        end
        SVC_ACTIVE: begin
          if (done_evt)  state  <= SVC_GAP;
          else if (xfer) remain <= remain - 1'b1;
        end
        default: state <= SVC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xfer_fifo_req.sv
module xfer_fifo_req
  import xfer_fifo_pkg::*;
#(
  parameter  int DEPTH = 32,
  localparam int TW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_mode,
  input  logic              drain_en,
  input  logic              slave_tx,
  input  logic [TW-1:0]     tx_thr_m1,
  input  logic [TW-1:0]     rx_thr_m1,
  input  logic              tx_clr,
  input  logic              rx_clr,
  input  logic              host_wr_en,
  input  logic [BYTE_W-1:0] host_wr_data,
  input  logic              host_rd_en,
  output logic [BYTE_W-1:0] host_rd_data,
  input  logic              core_tx_pop,
  output logic [BYTE_W-1:0] core_tx_data,
  output logic              core_tx_avail,
  input  logic              core_tx_byte_req,
  input  logic              core_rx_push,
  input  logic [BYTE_W-1:0] core_rx_data,
  output logic              core_rx_space,
  output logic              tx_irq,
  output logic              tx_dma_req,
  output logic              rx_irq,
  output logic              rx_dma_req,
  output logic [LW-1:0]     tx_level,
  output logic [LW-1:0]     rx_level,
  output logic [LW-1:0]     rx_drain_cnt,
  output logic              tx_ovf,
  output logic              rx_unf
);
  function automatic logic [LW-1:0] thr_decode(input logic [TW-1:0] f);
    return LW'(f) + LW'(1);
  endfunction

  function automatic logic [LW-1:0] min_len(input logic [LW-1:0] a, input logic [LW-1:0] b);
    return (a < b) ? a : b;
  endfunction

  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          tx_push_drop, tx_pop_drop, rx_push_drop, rx_pop_drop;
  logic [LW-1:0] tx_free, tx_thr, rx_thr, tx_burst, rx_burst;
  logic          tx_cond, rx_cond, tx_xfer, rx_xfer, tx_starve;
  logic          tx_arm_evt, tx_done_evt, rx_arm_evt, rx_done_evt;

  xfer_byte_fifo #(.DEPTH(DEPTH), .LW(LW)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr),
    .push(host_wr_en), .push_data(host_wr_data),
    .pop(core_tx_pop), .pop_data(core_tx_data),
    .level(tx_level), .full(tx_full), .empty(tx_empty),
    .push_drop(tx_push_drop), .pop_drop(tx_pop_drop)
  );

  xfer_byte_fifo #(.DEPTH(DEPTH), .LW(LW)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr),
    .push(core_rx_push), .push_data(core_rx_data),
    .pop(host_rd_en), .pop_data(host_rd_data),
    .level(rx_level), .full(rx_full), .empty(rx_empty),
    .push_drop(rx_push_drop), .pop_drop(rx_pop_drop)
  );

  assign tx_thr  = thr_decode(tx_thr_m1);
  assign rx_thr  = thr_decode(rx_thr_m1);
  assign tx_free = LW'(DEPTH) - tx_level;
  assign tx_xfer = host_wr_en & ~tx_full & ~tx_clr;
  assign rx_xfer = host_rd_en & ~rx_empty & ~rx_clr;

  always_comb begin
    if (slave_tx) begin
      tx_cond  = tx_starve;
      tx_burst = LW'(1);
    end else if (drain_en) begin
      tx_cond  = (tx_free != '0);
      tx_burst = min_len(tx_free, tx_thr);
    end else begin
      tx_cond  = (tx_free >= tx_thr);
      tx_burst = tx_thr;
    end
    if (drain_en) begin
      rx_cond  = (rx_level != '0);
      rx_burst = min_len(rx_level, rx_thr);
    end else begin
      rx_cond  = (rx_level >= rx_thr);
      rx_burst = rx_thr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_starve <= 1'b0;
      tx_ovf    <= 1'b0;
      rx_unf    <= 1'b0;
    end else begin
      if (tx_clr || tx_xfer)                tx_starve <= 1'b0;
      else if (core_tx_byte_req && tx_empty) tx_starve <= 1'b1;
      if (tx_clr)            tx_ovf <= 1'b0;
      else if (tx_push_drop) tx_ovf <= 1'b1;
      if (rx_clr)           rx_unf <= 1'b0;
      else if (rx_pop_drop) rx_unf <= 1'b1;
    end
  end

  xfer_svc_req #(.LW(LW)) u_tx_svc (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr), .dma_mode(dma_mode),
    .cond(tx_cond), .burst(tx_burst), .xfer(tx_xfer),
    .irq(tx_irq), .dma_req(tx_dma_req),
    .arm_evt(tx_arm_evt), .done_evt(tx_done_evt)
  );

  xfer_svc_req #(.LW(LW)) u_rx_svc (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .dma_mode(dma_mode),
    .cond(rx_cond), .burst(rx_burst), .xfer(rx_xfer),
    .irq(rx_irq), .dma_req(rx_dma_req),
    .arm_evt(rx_arm_evt), .done_evt(rx_done_evt)
  );

  assign core_tx_avail = ~tx_empty;
  assign core_rx_space = ~rx_full;
  assign rx_drain_cnt  = drain_en ? rx_level : '0;
endmodule

// File: rtl/xfer_fifo_chk.sv
module xfer_fifo_chk #(
  parameter int DEPTH = 32,
  parameter int LW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dma_mode,
  input logic          tx_clr,
  input logic          rx_clr,
  input logic          host_wr_en,
  input logic          host_rd_en,
  input logic          core_tx_pop,
  input logic          core_rx_push,
  input logic          core_tx_avail,
  input logic          tx_irq,
  input logic          rx_irq,
  input logic          tx_dma_req,
  input logic          rx_dma_req,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level,
  input logic          tx_ovf,
  input logic          rx_unf,
  input logic          tx_arm_evt,
  input logic          tx_done_evt,
  input logic          rx_arm_evt,
  input logic          rx_done_evt,
  input logic          tx_pop_drop,
  input logic          rx_push_drop
);
  AST_TX_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) tx_clr |=> tx_level == '0); // R9
  AST_RX_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) rx_clr |=> rx_level == '0); // R9
  AST_CLR_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n) (tx_clr |-> !tx_dma_req && !tx_irq) and (rx_clr |-> !rx_dma_req && !rx_irq)); // R9
  AST_NO_IRQ_IN_DMA: assert property (@(posedge clk) disable iff (!rst_n) dma_mode |-> !tx_irq && !rx_irq); // R4
  AST_TX_ARM_RISES: assert property (@(posedge clk) disable iff (!rst_n) tx_arm_evt |=> tx_dma_req || tx_clr); // R4
  AST_RX_ARM_RISES: assert property (@(posedge clk) disable iff (!rst_n) rx_arm_evt |=> rx_dma_req || rx_clr); // R4
  AST_TX_DONE_GAP: assert property (@(posedge clk) disable iff (!rst_n) tx_done_evt |=> !tx_dma_req); // R4
  AST_RX_DONE_GAP: assert property (@(posedge clk) disable iff (!rst_n) rx_done_evt |=> !rx_dma_req); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && tx_level == LW'(DEPTH) && !core_tx_pop && !tx_clr) |=> $stable(tx_level) && tx_ovf); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_en && rx_level == '0 && !core_rx_push && !rx_clr) |=> rx_level == '0 && rx_unf); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (tx_ovf && !tx_clr) |=> tx_ovf); // R8
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (rx_unf && !rx_clr) |=> rx_unf); // R8
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) tx_level <= LW'(DEPTH) && rx_level <= LW'(DEPTH)); // R3
  AST_TX_AVAIL: assert property (@(posedge clk) disable iff (!rst_n) core_tx_avail == (tx_level != '0)); // R3
  AST_TX_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (tx_pop_drop && !host_wr_en) |=> tx_level == '0); // R3
  AST_RX_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n) (rx_push_drop && !host_rd_en && !rx_clr) |=> rx_level == LW'(DEPTH)); // R3
  AST_SIMUL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && core_tx_pop && tx_level != '0 && tx_level != LW'(DEPTH) && !tx_clr) |=> $stable(tx_level)); // R10
endmodule

bind xfer_fifo_req xfer_fifo_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dma_mode(dma_mode),
  .tx_clr(tx_clr), .rx_clr(rx_clr),
  .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
  .core_tx_pop(core_tx_pop), .core_rx_push(core_rx_push),
  .core_tx_avail(core_tx_avail),
  .tx_irq(tx_irq), .rx_irq(rx_irq),
  .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
  .tx_level(tx_level), .rx_level(rx_level),
  .tx_ovf(tx_ovf), .rx_unf(rx_unf),
  .tx_arm_evt(tx_arm_evt), .tx_done_evt(tx_done_evt),
  .rx_arm_evt(rx_arm_evt), .rx_done_evt(rx_done_evt),
  .tx_pop_drop(tx_pop_drop), .rx_push_drop(rx_push_drop)
);

// File: tb/xfer_fifo_req_bench.sv
`timescale 1ns/1ps
module xfer_fifo_req_bench;
  localparam int DEPTH = 32;
  localparam int TW = 5;
  localparam int LW = 6;
  localparam int NV = 6;
  // columns: tx field, rx field, host writes, core pushes, expected tx_irq, expected rx_irq
  localparam int VEC [NV][6] = '{
    '{0,  0,  0,  0,  1, 0},
    '{7,  3,  24, 4,  1, 1},
    '{7,  3,  25, 3,  0, 0},
    '{31, 31, 0,  32, 1, 1},
    '{31, 31, 1,  31, 0, 0},
    '{15, 15, 16, 16, 1, 1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dma_mode = 1'b1, drain_en = 1'b0, slave_tx = 1'b0;
  logic [TW-1:0] tx_thr_m1 = '0, rx_thr_m1 = '0;
  logic tx_clr = 1'b0, rx_clr = 1'b0;
  logic host_wr_en = 1'b0, host_rd_en = 1'b0;
  logic [7:0] host_wr_data = '0, host_rd_data, core_tx_data, core_rx_data = '0;
  logic core_tx_pop = 1'b0, core_tx_byte_req = 1'b0, core_rx_push = 1'b0;
  logic core_tx_avail, core_rx_space, tx_irq, tx_dma_req, rx_irq, rx_dma_req;
  logic [LW-1:0] tx_level, rx_level, rx_drain_cnt;
  logic tx_ovf, rx_unf;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  xfer_fifo_req #(.DEPTH(DEPTH)) u_xfer_fifo_req (
    .clk(clk), .rst_n(rst_n), .dma_mode(dma_mode), .drain_en(drain_en), .slave_tx(slave_tx),
    .tx_thr_m1(tx_thr_m1), .rx_thr_m1(rx_thr_m1), .tx_clr(tx_clr), .rx_clr(rx_clr),
    .host_wr_en(host_wr_en), .host_wr_data(host_wr_data), .host_rd_en(host_rd_en),
    .host_rd_data(host_rd_data), .core_tx_pop(core_tx_pop), .core_tx_data(core_tx_data),
    .core_tx_avail(core_tx_avail), .core_tx_byte_req(core_tx_byte_req),
    .core_rx_push(core_rx_push), .core_rx_data(core_rx_data), .core_rx_space(core_rx_space),
    .tx_irq(tx_irq), .tx_dma_req(tx_dma_req), .rx_irq(rx_irq), .rx_dma_req(rx_dma_req),
    .tx_level(tx_level), .rx_level(rx_level), .rx_drain_cnt(rx_drain_cnt),
    .tx_ovf(tx_ovf), .rx_unf(rx_unf)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] b);
    @(negedge clk); host_wr_en = 1'b1; host_wr_data = b;
    @(negedge clk); host_wr_en = 1'b0;
  endtask

  task automatic host_read();
    @(negedge clk); host_rd_en = 1'b1;
    @(negedge clk); host_rd_en = 1'b0;
  endtask

  task automatic core_push(input logic [7:0] b);
    @(negedge clk); core_rx_push = 1'b1; core_rx_data = b;
    @(negedge clk); core_rx_push = 1'b0;
  endtask

  task automatic core_pop();
    @(negedge clk); core_tx_pop = 1'b1;
    @(negedge clk); core_tx_pop = 1'b0;
  endtask

  task automatic clear_both();
    @(negedge clk); tx_clr = 1'b1; rx_clr = 1'b1;
    @(negedge clk); tx_clr = 1'b0; rx_clr = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    // R1: reset state, sampled while reset is held
    repeat (3) @(negedge clk);
    chk("R1 tx_level", int'(tx_level), 0);
    chk("R1 rx_level", int'(rx_level), 0);
    chk("R1 tx_dma_req", int'(tx_dma_req), 0);
    chk("R1 rx_dma_req", int'(rx_dma_req), 0);
    chk("R1 tx_ovf", int'(tx_ovf), 0);
    chk("R1 rx_unf", int'(rx_unf), 0);
    chk("R1 core_tx_avail", int'(core_tx_avail), 0);
    chk("R1 core_rx_space", int'(core_rx_space), 1);
    rst_n = 1'b1;
    dma_mode = 1'b0;
    clear_both();

    // R2: threshold table in interrupt mode
    for (int v = 0; v < NV; v++) begin
      clear_both();
      tx_thr_m1 = TW'(VEC[v][0]);
      rx_thr_m1 = TW'(VEC[v][1]);
      for (int k = 0; k < VEC[v][2]; k++) host_write(8'(k));
      for (int k = 0; k < VEC[v][3]; k++) core_push(8'(k + 100));
      @(negedge clk);
      chk($sformatf("R2 vec%0d tx_irq", v), int'(tx_irq), VEC[v][4]);
      chk($sformatf("R2 vec%0d rx_irq", v), int'(rx_irq), VEC[v][5]);
      chk($sformatf("R2 vec%0d tx_level", v), int'(tx_level), VEC[v][2]);
      chk($sformatf("R2 vec%0d rx_level", v), int'(rx_level), VEC[v][3]);
    end

    // R3: order and one-byte serial side
    clear_both();
    tx_thr_m1 = '0; rx_thr_m1 = '0;
    host_write(8'hA1); host_write(8'hB2); host_write(8'hC3);
    chk("R3 tx avail", int'(core_tx_avail), 1);
    chk("R3 head0", int'(core_tx_data), 'hA1);
    core_pop();
    chk("R3 head1", int'(core_tx_data), 'hB2);
    core_pop();
    chk("R3 head2", int'(core_tx_data), 'hC3);
    core_pop();
    chk("R3 tx empty", int'(core_tx_avail), 0);
    core_push(8'h5A); core_push(8'h6B);
    chk("R3 rx head0", int'(host_rd_data), 'h5A);
    host_read();
    chk("R3 rx head1", int'(host_rd_data), 'h6B);
    host_read();
    chk("R3 rx level", int'(rx_level), 0);
    for (int k = 0; k < DEPTH; k++) core_push(8'(k));
    chk("R3 rx space full", int'(core_rx_space), 0);
    core_push(8'hEE);
    chk("R3 rx push when full ignored", int'(rx_level), DEPTH);
    chk("R3 rx head kept", int'(host_rd_data), 0);

    // R10: simultaneous write and pop
    clear_both();
    host_write(8'h11); host_write(8'h22);
    @(negedge clk); host_wr_en = 1'b1; host_wr_data = 8'h33; core_tx_pop = 1'b1;
    @(negedge clk); host_wr_en = 1'b0; core_tx_pop = 1'b0;
    chk("R10 level held", int'(tx_level), 2);
    chk("R10 next head", int'(core_tx_data), 'h22);

    // R8: overflow and underflow
    clear_both();
    for (int k = 0; k < DEPTH; k++) host_write(8'(k + 1));
    chk("R8 no ovf yet", int'(tx_ovf), 0);
    host_write(8'hFF);
    chk("R8 level after ovf", int'(tx_level), DEPTH);
    chk("R8 ovf set", int'(tx_ovf), 1);
    chk("R8 head unchanged", int'(core_tx_data), 1);
    host_read();
    chk("R8 unf set", int'(rx_unf), 1);
    chk("R8 rx level", int'(rx_level), 0);
    @(negedge clk);
    chk("R8 ovf sticky", int'(tx_ovf), 1);
    clear_both();
    chk("R8 ovf cleared", int'(tx_ovf), 0);
    chk("R8 unf cleared", int'(rx_unf), 0);

    // R4: DMA burst of 4
    tx_thr_m1 = TW'(3); rx_thr_m1 = TW'(7); dma_mode = 1'b1;
    @(negedge clk);
    chk("R4 tx dma rises", int'(tx_dma_req), 1);
    chk("R4 tx irq off", int'(tx_irq), 0);
    chk("R4 rx dma idle", int'(rx_dma_req), 0);
    host_write(8'h01); host_write(8'h02); host_write(8'h03);
    chk("R4 held mid burst", int'(tx_dma_req), 1);
    host_write(8'h04);
    chk("R4 drop after burst", int'(tx_dma_req), 0);
    @(negedge clk);
    chk("R4 gap second cycle", int'(tx_dma_req), 0);
    @(negedge clk);
    chk("R4 rearm", int'(tx_dma_req), 1);

    // R9: clear with simultaneous write during active burst
    @(negedge clk); tx_clr = 1'b1; host_wr_en = 1'b1; host_wr_data = 8'h99;
    #1;
    chk("R9 req low same cycle", int'(tx_dma_req), 0);
    @(negedge clk); tx_clr = 1'b0; host_wr_en = 1'b0;
    chk("R9 level zero", int'(tx_level), 0);

    // R5 and R6: receive drain in DMA mode
    core_push(8'h01); core_push(8'h02); core_push(8'h03);
    chk("R5 no rx req below thr", int'(rx_dma_req), 0);
    chk("R6 drain cnt off", int'(rx_drain_cnt), 0);
    @(negedge clk); drain_en = 1'b1;
    @(negedge clk);
    chk("R5 rx drain req", int'(rx_dma_req), 1);
    chk("R6 drain cnt", int'(rx_drain_cnt), 3);
    host_read(); host_read();
    chk("R5 rx held", int'(rx_dma_req), 1);
    host_read();
    chk("R5 rx burst of 3 done", int'(rx_dma_req), 0);
    chk("R5 rx emptied", int'(rx_level), 0);
    drain_en = 1'b0; dma_mode = 1'b0;
    clear_both();

    // R5: transmit drain in interrupt mode
    tx_thr_m1 = TW'(7);
    for (int k = 0; k < 30; k++) host_write(8'(k));
    chk("R5 tx irq off free 2", int'(tx_irq), 0);
    drain_en = 1'b1; #1;
    chk("R5 tx drain irq", int'(tx_irq), 1);
    drain_en = 1'b0;
    clear_both();

    // R7: slave transmit
    slave_tx = 1'b1; tx_thr_m1 = TW'(3); #1;
    chk("R7 no req without byte request", int'(tx_irq), 0);
    @(negedge clk); core_tx_byte_req = 1'b1;
    @(negedge clk); core_tx_byte_req = 1'b0;
    chk("R7 req on starve", int'(tx_irq), 1);
    host_write(8'h77);
    chk("R7 req withdrawn", int'(tx_irq), 0);
    @(negedge clk); core_tx_byte_req = 1'b1;
    @(negedge clk); core_tx_byte_req = 1'b0;
    chk("R7 no req when data present", int'(tx_irq), 0);
    slave_tx = 1'b0;
    clear_both();

    summary();
  end
endmodule